// File: doc/BRIEF.md
# Hidden Address Latch Update Unit

This block keeps the 16-bit hidden address latch of an 8-bit processor core and works out its next value each time an instruction retires. The decoder pulses a one-cycle update strobe together with an operation-class code and the operand values the class needs: an effective or target address, a register pair, the accumulator, BC, HL, the address of the instruction itself, an 8-bit port number, an index base with an 8-bit displacement, and the block-compare match flag. The block turns these into the new latch value and registers it on the same clock edge.

Each class follows its own rule. Some rules add one to an address. Some build the high byte from the accumulator. Some choose between the old latch and the instruction address according to the repeat condition. Some decrement B before forming BC. A variant-select input forces the accumulator-derived high byte to zero, which models the behaviour of some core derivatives. A host port reads the latch at any time through the output and can overwrite it directly. Decoding, bus timing, flags and the register file all sit outside this block.

Top module: `hptr_update`

## Requirements
- R1: While synchronous reset `rst` is high at a clock edge, the latch becomes 0x0000.
- R2: When `host_we` is high at an edge, the latch takes `host_wdata`, even if `upd_valid` is high in the same cycle. `latch_q` always shows the registered latch.
- R3: With `upd_valid` low, or with a class code in 19..31, the latch keeps its value.
- R4: Class 1 (address plus one) loads `opnd_addr + 1`, wrapping at 16 bits.
- R5: Class 2 (accumulator-high store) loads the low byte from `(opnd_addr + 1) & 0xFF`. The high byte is `opnd_acc`, or 0x00 when `hi_zero` is high.
- R6: Class 3 (stack exchange) loads `opnd_pair`. Class 4 (nibble rotate) loads `opnd_hl + 1`. Class 5 (16-bit arithmetic) loads `opnd_pair + 1`, where `opnd_pair` is the destination before the operation.
- R7: Class 6 (jump, call, return, restart or interrupt target) loads `opnd_addr` whether or not a branch condition holds.
- R8: Class 7 (input from an immediate port) loads `(opnd_acc << 8) + opnd_port + 1`, wrapping at 16 bits. Class 8 (I/O through C) loads `opnd_bc + 1`.
- R9: Class 9 (compare, increment) adds one to the latch. Class 10 (compare, decrement) subtracts one. Both wrap.
- R10: Classes 11 and 12 (repeating compare, increment or decrement) act as classes 9 and 10 when `opnd_bc == 1` or `cmp_match` is high. Otherwise they load `opnd_pc + 1`.
- R11: Class 13 (repeating block move) keeps the latch when `opnd_bc == 1` and otherwise loads `opnd_pc + 1`.
- R12: With `opnd_bc` holding BC before B is decremented: class 14 loads BC+1 and class 15 loads BC-1. Class 16 loads {B-1,C}+1 and class 17 loads {B-1,C}-1. All wrap at 16 bits and 8 bits.
- R13: Class 18 (indexed operand) loads `opnd_base` plus the sign-extended `opnd_disp`, wrapping at 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | One-cycle strobe marking a retiring instruction |
| upd_op | input | 5 | Operation-class code |
| opnd_addr | input | 16 | Effective, immediate or target address |
| opnd_pair | input | 16 | Register pair operand |
| opnd_acc | input | 8 | Accumulator before the operation |
| opnd_bc | input | 16 | BC before any decrement |
| opnd_hl | input | 16 | HL |
| opnd_pc | input | 16 | Address of the current instruction |
| opnd_port | input | 8 | Immediate port number |
| opnd_base | input | 16 | Index register value |
| opnd_disp | input | 8 | Signed displacement |
| cmp_match | input | 1 | Block compare found equality |
| hi_zero | input | 1 | Force the accumulator-derived high byte to zero |
| host_we | input | 1 | Host write enable |
| host_wdata | input | 16 | Host write data |
| latch_q | output | 16 | Current latch value |

## Verification
The bench builds the block with its default byte width of 8, which gives a 16-bit latch. This makes every wrap point reachable with a few directed values: 0xFFFF plus one, an accumulator-and-port sum that carries out of the top, B decrementing from 0x00, and negative displacements that borrow across the byte boundary. Each operation class gets its own task. The tasks also cover the repeat conditions (BC equal to one versus 0x0100, match against no match), a host write that collides with a strobe, and unassigned class codes.

// File: rtl/hptr_pkg.sv
package hptr_pkg;

  localparam int HP_BW  = 8;
  localparam int HP_OPW = 5;

  typedef enum logic [HP_OPW-1:0] {
    OP_NONE     = 5'd0,
    OP_ADDR_INC = 5'd1,
    OP_ACC_HI   = 5'd2,
    OP_EXSP     = 5'd3,
    OP_ROT_HL   = 5'd4,
    OP_ARITH16  = 5'd5,
    OP_TARGET   = 5'd6,
    OP_IN_IMM   = 5'd7,
    OP_IO_C     = 5'd8,
    OP_CMP_INC  = 5'd9,
    OP_CMP_DEC  = 5'd10,
    OP_CMPR_INC = 5'd11,
    OP_CMPR_DEC = 5'd12,
    OP_MOVE_RPT = 5'd13,
    OP_INP_INC  = 5'd14,
    OP_INP_DEC  = 5'd15,
    OP_OUTP_INC = 5'd16,
    OP_OUTP_DEC = 5'd17,
    OP_INDEXED  = 5'd18
  } hop_e;

endpackage

// File: rtl/hptr_arith.sv
module hptr_arith #(
  parameter int BW = hptr_pkg::HP_BW,
  localparam int AW = 2 * BW
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] opnd_addr,
  input  logic [AW-1:0] opnd_pair,
  input  logic [BW-1:0] opnd_acc,
  input  logic [AW-1:0] opnd_bc,
  input  logic [AW-1:0] opnd_hl,
  input  logic [AW-1:0] opnd_pc,
  input  logic [BW-1:0] opnd_port,
  input  logic [AW-1:0] opnd_base,
  input  logic [BW-1:0] opnd_disp,
  input  logic          hi_zero,
  output logic [AW-1:0] c_addr_inc,
  output logic [AW-1:0] c_acc_hi,
  output logic [AW-1:0] c_pair_inc,
  output logic [AW-1:0] c_hl_inc,
  output logic [AW-1:0] c_in_imm,
  output logic [AW-1:0] c_bc_inc,
  output logic [AW-1:0] c_bc_dec,
  output logic [AW-1:0] c_bdec_inc,
  output logic [AW-1:0] c_bdec_dec,
  output logic [AW-1:0] c_cur_inc,
  output logic [AW-1:0] c_cur_dec,
  output logic [AW-1:0] c_pc_inc,
  output logic [AW-1:0] c_indexed,
  output logic          bc_is_one
);

  localparam logic [AW-1:0] ONE_W = AW'(1);
  localparam logic [BW-1:0] ONE_B = BW'(1);

  logic [BW-1:0] b_minus;
  logic [AW-1:0] bc_after;
  logic [AW-1:0] disp_ext;
  logic [BW-1:0] hi_src;

  always_comb begin
    b_minus    = opnd_bc[AW-1:BW] - ONE_B;
    bc_after   = {b_minus, opnd_bc[BW-1:0]};
    disp_ext   = {{BW{opnd_disp[BW-1]}}, opnd_disp};
    hi_src     = hi_zero ? '0 : opnd_acc;

    c_addr_inc = opnd_addr + ONE_W;
    c_acc_hi   = {hi_src, c_addr_inc[BW-1:0]};
    c_pair_inc = opnd_pair + ONE_W;
    c_hl_inc   = opnd_hl + ONE_W;
    c_in_imm   = {opnd_acc, {BW{1'b0}}} + {{BW{1'b0}}, opnd_port} + ONE_W;
    c_bc_inc   = opnd_bc + ONE_W;
    c_bc_dec   = opnd_bc - ONE_W;
    c_bdec_inc = bc_after + ONE_W;
    c_bdec_dec = bc_after - ONE_W;
    c_cur_inc  = cur + ONE_W;
    c_cur_dec  = cur - ONE_W;
    c_pc_inc   = opnd_pc + ONE_W;
    c_indexed  = opnd_base + disp_ext;
    bc_is_one  = (opnd_bc == ONE_W);
  end

endmodule

// File: rtl/hptr_select.sv
module hptr_select #(
  parameter int BW = hptr_pkg::HP_BW,
  localparam int AW = 2 * BW,
  localparam int OPW = hptr_pkg::HP_OPW
) (
  input  logic [OPW-1:0] op,
  input  logic [AW-1:0]  cur,
  input  logic [AW-1:0]  opnd_addr,
  input  logic [AW-1:0]  opnd_pair,
  input  logic           cmp_match,
  input  logic           bc_is_one,
  input  logic [AW-1:0]  c_addr_inc,
  input  logic [AW-1:0]  c_acc_hi,
  input  logic [AW-1:0]  c_pair_inc,
  input  logic [AW-1:0]  c_hl_inc,
  input  logic [AW-1:0]  c_in_imm,
  input  logic [AW-1:0]  c_bc_inc,
  input  logic [AW-1:0]  c_bc_dec,
  input  logic [AW-1:0]  c_bdec_inc,
  input  logic [AW-1:0]  c_bdec_dec,
  input  logic [AW-1:0]  c_cur_inc,
  input  logic [AW-1:0]  c_cur_dec,
  input  logic [AW-1:0]  c_pc_inc,
  input  logic [AW-1:0]  c_indexed,
  output logic [AW-1:0]  nxt
);

  import hptr_pkg::*;

  logic rpt_stop;

  always_comb begin
    rpt_stop = bc_is_one | cmp_match;
    nxt      = cur;
    case (op)
      OP_ADDR_INC: nxt = c_addr_inc;
      OP_ACC_HI:   nxt = c_acc_hi;
      OP_EXSP:     nxt = opnd_pair;
      OP_ROT_HL:   nxt = c_hl_inc;
      OP_ARITH16:  nxt = c_pair_inc;
      OP_TARGET:   nxt = opnd_addr;
      OP_IN_IMM:   nxt = c_in_imm;
      OP_IO_C:     nxt = c_bc_inc;
      OP_CMP_INC:  nxt = c_cur_inc;
      OP_CMP_DEC:  nxt = c_cur_dec;
      OP_CMPR_INC: nxt = rpt_stop ? c_cur_inc : c_pc_inc;
      OP_CMPR_DEC: nxt = rpt_stop ? c_cur_dec : c_pc_inc;
      OP_MOVE_RPT: nxt = bc_is_one ? cur : c_pc_inc;
      OP_INP_INC:  nxt = c_bc_inc;
      OP_INP_DEC:  nxt = c_bc_dec;
      OP_OUTP_INC: nxt = c_bdec_inc;
      OP_OUTP_DEC: nxt = c_bdec_dec;
      OP_INDEXED:  nxt = c_indexed;
      default:     nxt = cur;
    endcase
  end

endmodule

// File: rtl/hptr_reg.sv
module hptr_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [AW-1:0] host_wdata,
  input  logic          upd_valid,
  input  logic [AW-1:0] nxt,
  output logic [AW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)            q <= '0;
    else if (host_we)   q <= host_wdata;
    else if (upd_valid) q <= nxt;
  end

endmodule

// File: rtl/hptr_update.sv
module hptr_update #(
  parameter int BW = hptr_pkg::HP_BW,
  localparam int AW = 2 * BW,
  localparam int OPW = hptr_pkg::HP_OPW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           upd_valid,
  input  logic [OPW-1:0] upd_op,
  input  logic [AW-1:0]  opnd_addr,
  input  logic [AW-1:0]  opnd_pair,
  input  logic [BW-1:0]  opnd_acc,
  input  logic [AW-1:0]  opnd_bc,
  input  logic [AW-1:0]  opnd_hl,
  input  logic [AW-1:0]  opnd_pc,
  input  logic [BW-1:0]  opnd_port,
  input  logic [AW-1:0]  opnd_base,
  input  logic [BW-1:0]  opnd_disp,
  input  logic           cmp_match,
  input  logic           hi_zero,
  input  logic           host_we,
  input  logic [AW-1:0]  host_wdata,
  output logic [AW-1:0]  latch_q
);

  logic [AW-1:0] c_addr_inc, c_acc_hi, c_pair_inc, c_hl_inc, c_in_imm;
  logic [AW-1:0] c_bc_inc, c_bc_dec, c_bdec_inc, c_bdec_dec;
  logic [AW-1:0] c_cur_inc, c_cur_dec, c_pc_inc, c_indexed;
  logic          bc_is_one;
  logic [AW-1:0] nxt;

  hptr_arith #(.BW(BW)) u_arith (
    .cur(latch_q), .opnd_addr(opnd_addr), .opnd_pair(opnd_pair),
    .opnd_acc(opnd_acc), .opnd_bc(opnd_bc), .opnd_hl(opnd_hl),
    .opnd_pc(opnd_pc), .opnd_port(opnd_port), .opnd_base(opnd_base),
    .opnd_disp(opnd_disp), .hi_zero(hi_zero),
    .c_addr_inc(c_addr_inc), .c_acc_hi(c_acc_hi), .c_pair_inc(c_pair_inc),
    .c_hl_inc(c_hl_inc), .c_in_imm(c_in_imm), .c_bc_inc(c_bc_inc),
    .c_bc_dec(c_bc_dec), .c_bdec_inc(c_bdec_inc), .c_bdec_dec(c_bdec_dec),
    .c_cur_inc(c_cur_inc), .c_cur_dec(c_cur_dec), .c_pc_inc(c_pc_inc),
    .c_indexed(c_indexed), .bc_is_one(bc_is_one)
  );

  hptr_select #(.BW(BW)) u_select (
    .op(upd_op), .cur(latch_q), .opnd_addr(opnd_addr), .opnd_pair(opnd_pair),
    .cmp_match(cmp_match), .bc_is_one(bc_is_one),
    .c_addr_inc(c_addr_inc), .c_acc_hi(c_acc_hi), .c_pair_inc(c_pair_inc),
    .c_hl_inc(c_hl_inc), .c_in_imm(c_in_imm), .c_bc_inc(c_bc_inc),
    .c_bc_dec(c_bc_dec), .c_bdec_inc(c_bdec_inc), .c_bdec_dec(c_bdec_dec),
    .c_cur_inc(c_cur_inc), .c_cur_dec(c_cur_dec), .c_pc_inc(c_pc_inc),
    .c_indexed(c_indexed), .nxt(nxt)
  );

  hptr_reg #(.AW(AW)) u_reg (
    .clk(clk), .rst(rst), .host_we(host_we), .host_wdata(host_wdata),
    .upd_valid(upd_valid), .nxt(nxt), .q(latch_q)
  );

endmodule

// File: rtl/hptr_update_chk.sv
module hptr_update_chk #(
  parameter int BW = hptr_pkg::HP_BW,
  localparam int AW = 2 * BW,
  localparam int OPW = hptr_pkg::HP_OPW
) (
  input logic           clk,
  input logic           rst,
  input logic           upd_valid,
  input logic [OPW-1:0] upd_op,
  input logic [AW-1:0]  opnd_addr,
  input logic [AW-1:0]  opnd_bc,
  input logic           host_we,
  input logic [AW-1:0]  host_wdata,
  input logic [AW-1:0]  latch_q
);

  import hptr_pkg::*;

  logic rst_seen_q = 1'b0;
  always_ff @(posedge clk) rst_seen_q <= rst;

  logic upd_take;
  assign upd_take = upd_valid && !host_we;

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst_seen_q |-> latch_q == '0); // R1

  AST_HOST_LOAD: assert property (@(posedge clk) disable iff (rst)
    host_we |=> latch_q == $past(host_wdata)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!host_we && !upd_valid) |=> $stable(latch_q)); // R3

  AST_TARGET_LOAD: assert property (@(posedge clk) disable iff (rst)
    (upd_take && upd_op == OP_TARGET) |=> latch_q == $past(opnd_addr)); // R7

  AST_CMP_STEP: assert property (@(posedge clk) disable iff (rst)
    (upd_take && upd_op == OP_CMP_INC) |=> latch_q == AW'($past(latch_q) + AW'(1))); // R9

  AST_MOVE_LAST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (upd_take && upd_op == OP_MOVE_RPT && opnd_bc == AW'(1)) |=> $stable(latch_q)); // R11

endmodule

bind hptr_update hptr_update_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_op(upd_op),
  .opnd_addr(opnd_addr), .opnd_bc(opnd_bc), .host_we(host_we),
  .host_wdata(host_wdata), .latch_q(latch_q)
);

// File: tb/hptr_update_tb.sv
module hptr_update_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_valid = 1'b0;
  logic [4:0]  upd_op = '0;
  logic [15:0] opnd_addr = '0, opnd_pair = '0, opnd_bc = '0, opnd_hl = '0;
  logic [15:0] opnd_pc = '0, opnd_base = '0, host_wdata = '0;
  logic [7:0]  opnd_acc = '0, opnd_port = '0, opnd_disp = '0;
  logic        cmp_match = 1'b0, hi_zero = 1'b0, host_we = 1'b0;
  logic [15:0] latch_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hptr_update u_dut (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_op(upd_op),
    .opnd_addr(opnd_addr), .opnd_pair(opnd_pair), .opnd_acc(opnd_acc),
    .opnd_bc(opnd_bc), .opnd_hl(opnd_hl), .opnd_pc(opnd_pc),
    .opnd_port(opnd_port), .opnd_base(opnd_base), .opnd_disp(opnd_disp),
    .cmp_match(cmp_match), .hi_zero(hi_zero), .host_we(host_we),
    .host_wdata(host_wdata), .latch_q(latch_q)
  );

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (latch_q !== exp) begin
      errors++;
      $display("FAIL %s: latch_q=%h expected=%h", req, latch_q, exp);
    end
  endtask

  // Drive at falling edge, capture at the rising edge, sample at next falling edge.
  task automatic strobe(input logic [4:0] op);
    @(negedge clk);
    upd_op = op;
    upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic host_load(input logic [15:0] v);
    @(negedge clk);
    host_we = 1'b1;
    host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", 16'h0000);
    rst = 1'b0;
  endtask

  task automatic t_host;
    host_load(16'h1234);
    check("R2 host write", 16'h1234);
    @(negedge clk);
    host_we = 1'b1; host_wdata = 16'h5555;
    opnd_addr = 16'hAAAA; upd_op = 5'd6; upd_valid = 1'b1;
    @(negedge clk);
    host_we = 1'b0; upd_valid = 1'b0;
    check("R2 host beats strobe", 16'h5555);
  endtask

  task automatic t_hold;
    host_load(16'h0BAD);
    opnd_addr = 16'h7777; upd_op = 5'd1;
    repeat (2) @(negedge clk);
    check("R3 no strobe", 16'h0BAD);
    strobe(5'd19);
    check("R3 code 19", 16'h0BAD);
    strobe(5'd31);
    check("R3 code 31", 16'h0BAD);
    strobe(5'd0);
    check("R3 code 0", 16'h0BAD);
  endtask

  task automatic t_addr_inc;
    opnd_addr = 16'h3A00; strobe(5'd1);
    check("R4 addr+1", 16'h3A01);
    opnd_addr = 16'hFFFF; strobe(5'd1);
    check("R4 wrap", 16'h0000);
  endtask

  task automatic t_acc_hi;
    opnd_addr = 16'h12FF; opnd_acc = 8'h9C; hi_zero = 1'b0; strobe(5'd2);
    check("R5 acc high, low wraps", 16'h9C00);
    hi_zero = 1'b1; strobe(5'd2);
    check("R5 zero high", 16'h0000);
    hi_zero = 1'b0; opnd_addr = 16'h0041; opnd_acc = 8'h7E; strobe(5'd2);
    check("R5 acc high", 16'h7E42);
  endtask

  task automatic t_pairs;
    opnd_pair = 16'hBEEF; strobe(5'd3);
    check("R6 exchange", 16'hBEEF);
    opnd_hl = 16'hFFFF; strobe(5'd4);
    check("R6 rotate hl+1 wrap", 16'h0000);
    opnd_pair = 16'h8000; strobe(5'd5);
    check("R6 arith dest+1", 16'h8001);
  endtask

  task automatic t_target;
    opnd_addr = 16'h4321; strobe(5'd6);
    check("R7 target", 16'h4321);
  endtask

  task automatic t_io;
    opnd_acc = 8'h12; opnd_port = 8'hFF; strobe(5'd7);
    check("R8 in imm carry", 16'(16'h1200 + 16'h00FF + 16'h1));
    opnd_acc = 8'hFF; strobe(5'd7);
    check("R8 in imm wrap", 16'h0000);
    opnd_bc = 16'h00FF; strobe(5'd8);
    check("R8 io via C", 16'h0100);
  endtask

  task automatic t_cmp;
    host_load(16'hFFFF);
    strobe(5'd9);
    check("R9 cmp inc wrap", 16'h0000);
    strobe(5'd10);
    check("R9 cmp dec wrap", 16'hFFFF);
  endtask

  task automatic t_cmp_rpt;
    host_load(16'h1000);
    opnd_bc = 16'h0005; cmp_match = 1'b0; opnd_pc = 16'h2000; strobe(5'd11);
    check("R10 repeat inc continue", 16'h2001);
    cmp_match = 1'b1; strobe(5'd11);
    check("R10 repeat inc match", 16'h2002);
    cmp_match = 1'b0; opnd_bc = 16'h0001; strobe(5'd12);
    check("R10 repeat dec bc one", 16'h2001);
    opnd_bc = 16'h0003; opnd_pc = 16'h0100; strobe(5'd12);
    check("R10 repeat dec continue", 16'h0101);
  endtask

  task automatic t_move_rpt;
    opnd_bc = 16'h0001; opnd_pc = 16'h5000; strobe(5'd13);
    check("R11 last move holds", 16'h0101);
    opnd_bc = 16'h0002; opnd_pc = 16'h7FFF; strobe(5'd13);
    check("R11 move continue", 16'h8000);
    opnd_bc = 16'h0100; opnd_pc = 16'h0010; strobe(5'd13);
    check("R11 bc 0x0100 continues", 16'h0011);
  endtask

  task automatic t_block_io;
    opnd_bc = 16'h0203;
    strobe(5'd14); check("R12 in inc", 16'h0204);
    strobe(5'd15); check("R12 in dec", 16'h0202);
    strobe(5'd16); check("R12 out inc", 16'h0104);
    strobe(5'd17); check("R12 out dec", 16'h0102);
    opnd_bc = 16'h0000; strobe(5'd16);
    check("R12 out inc B wraps", 16'hFF01);
    opnd_bc = 16'h0100; strobe(5'd17);
    check("R12 out dec borrow", 16'hFFFF);
  endtask

  task automatic t_indexed;
    opnd_base = 16'h1000; opnd_disp = 8'h80; strobe(5'd18);
    check("R13 negative disp", 16'h0F80);
    opnd_disp = 8'h7F; strobe(5'd18);
    check("R13 positive disp", 16'h107F);
    opnd_base = 16'hFFFF; opnd_disp = 8'h01; strobe(5'd18);
    check("R13 wrap", 16'h0000);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: latch_q=%h expected=completion", latch_q);
    finish_run();
  end

  initial begin
    t_reset();
    t_host();
    t_hold();
    t_addr_inc();
    t_acc_hi();
    t_pairs();
    t_target();
    t_io();
    t_cmp();
    t_cmp_rpt();
    t_move_rpt();
    t_block_io();
    t_indexed();
    host_load(16'hCAFE);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset after use", 16'h0000);
    finish_run();
  end

endmodule